// File: doc/BRIEF.md
# Request-Paced Memory-to-Port DMA Channel

This block is a single DMA channel that copies a block of words from memory to one fixed device location, such as an audio sample port. Software loads a source address, a destination address and a unit count, then enables the channel. Each rising edge on the device's request line moves one word. The channel reads the word at the current source address, writes it to the destination, advances the source by one word and lowers the count by one. When the count reaches zero, the channel raises a completion flag and, if asked to, pulses an interrupt.

Restarting is cheap, which suits double-buffered streaming. After a run ends, software reloads only the source address and the count, and one control write both clears the completion flag and re-arms the channel. The destination register keeps its value across runs.

A global operation register holds a master enable and two error flags. One flag records an NMI event and the other records an address-alignment fault. Either flag halts transfers until software clears it. Every flag in the block clears only through a read that saw it set, followed by a write of 0 to its bit.

Top module: `cs_dma_chan`

## Requirements
- R1: After reset, all five registers read 0, `bus_req` is 0 and `irq` is 0.
- R2: Register index 0 is the source, 1 the destination, 2 the count and 3 the channel control. Control bit 0 is enable, bit 1 is the end flag and bit 2 is the interrupt enable. Index 4 is the operation register: bit 0 is master enable, bit 1 the alignment-error flag and bit 2 the NMI flag. The source, destination, count, enable, interrupt-enable and master-enable fields read back what was written.
- R3: One unit moves for each rising edge of `dreq`. Holding `dreq` high moves only one unit.
- R4: A unit is one bus read at the source address followed by one bus write of the returned data to the destination address (`bus_we`=1). Each access holds its address until `bus_rdy` is sampled high.
- R5: After each unit, the source address rises by 4, the count falls by 1 and the destination is unchanged.
- R6: When the count reaches 0, control bit 1 is set and further request edges cause no bus access.
- R7: At completion, `irq` is high for exactly one cycle if control bit 2 is set, and stays low if it is clear.
- R8: A control write with bit 1 = 0 clears the end flag only if a control read returned bit 1 = 1 since the last control write. Without that read, the flag stays set and the channel stays stopped.
- R9: After completion and a read of the flag, a control write of 0x5 clears the flag and restarts the channel. A run then proceeds after reloading only the source and count, and writes go to the retained destination.
- R10: No transfer starts while master enable is 0, or while either error flag is set. `nmi_in` high sets operation bit 2. A start with a source or destination address not a multiple of 4 sets operation bit 1 and makes no bus access. Each error flag clears like the end flag, by a read seeing it set followed by a write of 0 to its bit.
- R11: One request edge that arrives during a transfer is held and served after that transfer. Further edges during the same transfer are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks flags as seen) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Device request, rising-edge active |
| nmi_in | input | 1 | Non-maskable event, sets the NMI flag |
| bus_req | output | 1 | Bus access active |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_rdy | input | 1 | Access completes on this cycle |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The main run is swept over bus wait states of 0 to 3 and unit counts of 1 to 4. Each run has two surplus request pulses, so counting writes separates a correct stop at zero from both an off-by-one and a runaway. The read data is an arithmetic hash of the address, so every write's data and address show whether the source stepped correctly and whether the destination stayed fixed. Further patterns cover:
- a held request level, which must not act as a repeat edge;
- a fast three-pulse burst under slow bus responses, which shows one-deep pending;
- clear-without-read versus read-then-clear, which shows the flag protocol;
- master-off, NMI and misaligned starts, which must produce no bus activity.

// File: rtl/cs_dma_chan.sv
module cs_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int UNIT_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    dreq,
  input  logic                    nmi_in,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [AW-1:0]           bus_addr,
  output logic [8*UNIT_BYTES-1:0] bus_wdata,
  input  logic [8*UNIT_BYTES-1:0] bus_rdata,
  input  logic                    bus_rdy,
  output logic                    irq
);
  localparam int DW = 8 * UNIT_BYTES;
  localparam int AL = $clog2(UNIT_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic en, done, ie, men, aerr, nmif;
  logic done_seen, aerr_seen, nmif_seen;
  logic dreq_q, pend;

  wire active = en & ~done & men & ~aerr & ~nmif & (cnt != '0);
  wire rise   = dreq & ~dreq_q;
  wire start  = (st == S_IDLE) & pend & active;
  wire misal  = (src[AL-1:0] != '0) | (dst[AL-1:0] != '0);

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? dst : src;
  assign bus_wdata = hold;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(src);
      3'd1:    reg_rdata = 32'(dst);
      3'd2:    reg_rdata = 32'(cnt);
      3'd3:    reg_rdata = {29'd0, ie, done, en};
      3'd4:    reg_rdata = {29'd0, nmif, aerr, men};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; src <= '0; dst <= '0; cnt <= '0; hold <= '0;
      en <= 1'b0; done <= 1'b0; ie <= 1'b0; men <= 1'b0; aerr <= 1'b0; nmif <= 1'b0;
      done_seen <= 1'b0; aerr_seen <= 1'b0; nmif_seen <= 1'b0;
      dreq_q <= 1'b0; pend <= 1'b0; irq <= 1'b0;
    end else begin
      dreq_q <= dreq;
      irq    <= 1'b0;
      pend   <= active & ((pend & ~start) | rise);
      if (nmi_in) nmif <= 1'b1;

      case (st)
        S_IDLE: if (start) begin
          if (misal) aerr <= 1'b1;
          else       st <= S_RD;
        end
        S_RD: if (bus_rdy) begin
          hold <= bus_rdata;
          st   <= S_WR;
        end
        S_WR: if (bus_rdy) begin
          st  <= S_IDLE;
          src <= src + AW'(UNIT_BYTES);
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            done <= 1'b1;
            irq  <= ie;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (reg_rd && reg_addr == 3'd3 && done) done_seen <= 1'b1;
      if (reg_rd && reg_addr == 3'd4) begin
        if (aerr) aerr_seen <= 1'b1;
        if (nmif) nmif_seen <= 1'b1;
      end

      if (reg_wr) begin
        case (reg_addr)
          3'd0: src <= reg_wdata[AW-1:0];
          3'd1: dst <= reg_wdata[AW-1:0];
          3'd2: cnt <= reg_wdata[CW-1:0];
          3'd3: begin
            en <= reg_wdata[0];
            ie <= reg_wdata[2];
            if (!reg_wdata[1] && done_seen) done <= 1'b0;
            done_seen <= 1'b0;
          end
          3'd4: begin
            men <= reg_wdata[0];
            if (!reg_wdata[1] && aerr_seen) aerr <= 1'b0;
            if (!reg_wdata[2] && nmif_seen) nmif <= 1'b0;
            aerr_seen <= 1'b0;
            nmif_seen <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_rdy |=> bus_req && bus_we);
  a_r5_source_steps: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_rdy && !reg_wr |=> src == $past(src) + AW'(UNIT_BYTES));
  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && !bus_req && !reg_wr |=> !bus_req);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done && ie);
  a_r10_flags_block: assert property (@(posedge clk) disable iff (!rst_n)
    (aerr || nmif || !men) && !bus_req && !reg_wr |=> !bus_req);
endmodule

// File: tb/test_cs_dma_chan.sv
module test_cs_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dreq = 1'b0, nmi_in = 1'b0;
  logic bus_req, bus_we, bus_rdy = 1'b0, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0, lat = 0, wcnt = 0, cyc = 0;
  logic [31:0] exp_src = '0, exp_dst = '0, tmp;

  always #10 clk = ~clk;

  cs_dma_chan i_cs_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .nmi_in(nmi_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .irq(irq));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  assign bus_rdata = pat(bus_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (bus_req) begin
        if (wcnt == lat) begin
          bus_rdy <= 1'b1;
          wcnt = 0;
          if (bus_we) begin
            check("R4 write address", bus_addr, exp_dst);
            check("R4 write data", bus_wdata, pat(exp_src));
            exp_src += 4;
            wr_cnt++;
          end else begin
            check("R5 read address", bus_addr, exp_src);
            rd_cnt++;
          end
        end else begin
          bus_rdy <= 1'b0;
          wcnt++;
        end
      end else begin
        bus_rdy <= 1'b0;
        wcnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1'b1;
    repeat (2) @(negedge clk);
    dreq = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n, input logic [31:0] c);
    logic [31:0] r;
    reg_write(3'd0, s); reg_write(3'd1, d); reg_write(3'd2, n);
    reg_read(3'd3, r);
    reg_write(3'd3, c);
    exp_src = s; exp_dst = d;
  endtask

  initial begin
    int w0, i0, r0;
    repeat (3) @(negedge clk);
    check("R1 bus_req", {31'd0, bus_req}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), tmp);
      check("R1 register reset", tmp, 0);
    end

    reg_write(3'd0, 32'h12345678); reg_read(3'd0, tmp); check("R2 source", tmp, 32'h12345678);
    reg_write(3'd1, 32'hCAFEBAB0); reg_read(3'd1, tmp); check("R2 dest", tmp, 32'hCAFEBAB0);
    reg_write(3'd2, 32'h00ABCDEF); reg_read(3'd2, tmp); check("R2 count", tmp, 32'h00ABCDEF);
    reg_write(3'd3, 32'h4); reg_read(3'd3, tmp); check("R2 control", tmp, 32'h4);
    reg_write(3'd4, 32'h1); reg_read(3'd4, tmp); check("R2 operation", tmp, 32'h1);

    for (int l = 0; l < 4; l++) begin
      for (int n = 1; n <= 4; n++) begin
        logic [31:0] s, d;
        lat = l;
        s = 32'h100 * n + 32'h1000 * l;
        d = 32'h8000 + 32'h10 * l;
        setup(s, d, n, 32'h5);
        w0 = wr_cnt; i0 = irq_cnt;
        repeat (n + 2) pulse();
        check("R3 R6 units moved", wr_cnt - w0, n);
        check("R7 irq count", irq_cnt - i0, 1);
        reg_read(3'd0, tmp); check("R5 final source", tmp, s + 4 * n);
        reg_read(3'd2, tmp); check("R5 final count", tmp, 0);
        reg_read(3'd1, tmp); check("R5 dest fixed", tmp, d);
        reg_read(3'd3, tmp); check("R6 end flag", tmp, 32'h7);
      end
    end

    setup(32'h2000, 32'h9000, 3, 32'h5);
    w0 = wr_cnt;
    @(negedge clk); dreq = 1'b1;
    repeat (40) @(negedge clk);
    dreq = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 level is one edge", wr_cnt - w0, 1);
    reg_read(3'd2, tmp); check("R3 count after level", tmp, 2);

    lat = 3;
    setup(32'h3000, 32'h9100, 4, 32'h5);
    w0 = wr_cnt;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); dreq = 1'b1;
      @(negedge clk); dreq = 1'b0;
    end
    repeat (40) @(negedge clk);
    check("R11 one pending edge", wr_cnt - w0, 2);
    reg_read(3'd2, tmp); check("R11 count", tmp, 2);

    lat = 1;
    setup(32'h4000, 32'h9200, 1, 32'h1);
    w0 = wr_cnt; i0 = irq_cnt;
    pulse();
    check("R7 unit without irq", wr_cnt - w0, 1);
    check("R7 irq disabled", irq_cnt - i0, 0);

    reg_write(3'd0, 32'h5000); reg_write(3'd2, 2);
    reg_write(3'd3, 32'h5);
    w0 = wr_cnt;
    pulse();
    check("R8 no clear without read", wr_cnt - w0, 0);
    reg_read(3'd3, tmp); check("R8 flag still set", tmp, 32'h7);
    reg_write(3'd3, 32'h5);
    exp_src = 32'h5000;
    reg_read(3'd3, tmp); check("R9 flag cleared and enabled", tmp, 32'h5);
    pulse(); pulse();
    check("R9 restart units", wr_cnt - w0, 2);
    reg_read(3'd1, tmp); check("R9 dest retained", tmp, 32'h9200);
    reg_read(3'd3, tmp); check("R9 end again", tmp, 32'h7);

    setup(32'h6000, 32'h9300, 2, 32'h5);
    reg_write(3'd4, 32'h0);
    w0 = wr_cnt;
    pulse();
    check("R10 master off", wr_cnt - w0, 0);
    reg_write(3'd4, 32'h1);
    pulse();
    check("R10 master on", wr_cnt - w0, 1);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    reg_read(3'd4, tmp); check("R10 nmi flag", tmp, 32'h5);
    pulse();
    check("R10 nmi blocks", wr_cnt - w0, 1);
    reg_write(3'd4, 32'h1);
    reg_read(3'd4, tmp); check("R10 nmi cleared", tmp, 32'h1);
    pulse();
    check("R10 resumes", wr_cnt - w0, 2);

    setup(32'h7002, 32'h9400, 1, 32'h5);
    r0 = rd_cnt;
    pulse();
    check("R10 misaligned no access", rd_cnt - r0, 0);
    reg_read(3'd4, tmp); check("R10 align flag", tmp, 32'h3);
    reg_write(3'd4, 32'h1);
    reg_read(3'd4, tmp); check("R10 align cleared", tmp, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule